// File: doc/BRIEF.md
# Dual-Bank Full-Rate FIFO

A synchronous first-in first-out buffer that moves one item per clock even though each of its two storage banks is built around a single-port memory and can therefore take only one access per cycle. Accepted items are dealt alternately to bank 0 and bank 1. The read side collects them from the banks in the same alternating order, so global order is kept. The recombined stream then passes through a small register queue that drives the output port.

Both ports use a valid/wait handshake: a transfer happens in a cycle where valid is high and wait is low. An occupancy count, a synchronous clear and a synchronous active-low reset complete the interface. The price of the interleaving is a fixed pipeline latency of six cycles through an empty buffer.

Top module: `dual_bank_fifo`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `out_valid` is 0, `count` is 0 and `in_wait` is 0.
- R2: An input item is taken exactly in a cycle with `in_valid`=1 and `in_wait`=0. An output item is delivered exactly in a cycle with `out_valid`=1 and `out_wait`=0. `out_valid` is never high while the buffer holds nothing.
- R3: Items leave in the same order they were taken, with their data unchanged.
- R4: An item offered to an empty buffer in cycle c, with `out_wait` low, is taken in cycle c and shows `out_valid`=1 first in cycle c+6. The clock edge that closes cycle c+5 is the fifth edge after the accepting edge.
- R5: With `in_valid` held high and `out_wait` held low, `in_wait` stays 0, and after the initial latency one item leaves every cycle, each exactly six cycles after it entered.
- R6: `count` (AW+2 bits) equals items taken minus items delivered. It changes at the clock edge that closes the transfer cycle.
- R7: With `out_wait` held high, exactly 2*(2^AW + BANK_RF) + OUT_RF items are taken, after which `in_wait` stays 1. For AW=3, BANK_RF=4 and OUT_RF=2 this is 26.
- R8: An item offered while `in_wait` is 1 is not stored. `count` and the delivered sequence are unchanged by it.
- R9: While `out_valid`=1 and `out_wait`=1 (and `clr`=0), the next cycle still shows `out_valid`=1 with the same `out_data`.
- R10: In a cycle with `clr`=1, `in_wait` reads 1 and `out_valid` reads 0, and all content is discarded. In the next cycle `count` is 0. Items taken afterwards start again at bank 0 and emerge in order with the R4 latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| clr | input | 1 | Synchronous flush of all content |
| in_valid | input | 1 | Producer offers `in_data` |
| in_data | input | DW | Item to store |
| in_wait | output | 1 | Buffer cannot take an item this cycle |
| out_valid | output | 1 | `out_data` holds the oldest item |
| out_data | output | DW | Oldest item |
| out_wait | input | 1 | Consumer refuses the item this cycle |
| count | output | AW+2 | Items currently held |

## Verification
A single item sent into an empty buffer isolates the pipeline depth: an off-by-one in any stage of the memory read path or the two register queues shifts the first valid cycle away from six. An unbroken stream with no backpressure separates a correct interleave from one where a bank write and a bank read collide, because any such stall raises `in_wait` or inserts a gap at the output. Holding the output while streaming in measures the exact capacity and exercises the refused-input case. A long pseudo-random mix of offers, backpressure and occasional flushes, checked against a reference queue, tests ordering across the toggle pointers, holding under backpressure and the count every cycle.

// File: rtl/dbf_pkg.sv
// Shared definitions for the dual-bank FIFO.
// Assumes exactly two banks; the steering logic toggles between them.
package dbf_pkg;

    localparam int unsigned NUM_BANKS = 2;

    // Which bank a steering pointer currently addresses.
    typedef enum logic {
        SEL_B0 = 1'b0,
        SEL_B1 = 1'b1
    } bank_sel_e;

endpackage

// File: rtl/dbf_sp_ram.sv
// Single-port memory with registered inputs and a two-register read path.
// One access per cycle: the registered address serves either the write
// (when the registered write enable is set) or a read. Read data appears
// three edges after the address is presented. Holds no reset on data.
module dbf_sp_ram #(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic [AW-1:0] addr,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    localparam int SZ = 1 << AW;

    logic [DW-1:0] cells [SZ];
    logic [AW-1:0] addr_q;
    logic          we_q;
    logic [DW-1:0] wdata_q;
    logic [DW-1:0] stage1;

    // Capture the request of this cycle.
    always_ff @(posedge clk) begin : p_req
        addr_q  <= addr;
        we_q    <= we;
        wdata_q <= wdata;
    end

    // Perform the captured access, then retime the read word once more.
    always_ff @(posedge clk) begin : p_access
        if (we_q) begin
            cells[addr_q] <= wdata_q;
        end
        stage1 <= cells[addr_q];
        rdata  <= stage1;
    end

endmodule

// File: rtl/dbf_reg_fifo.sv
// Small register-based FIFO, one push and one pop per cycle, no bypass:
// an item pushed at an edge is visible at the head after that edge.
// Assumes the producer never pushes while full and the consumer never
// pops while empty. DEPTH need not be a power of two (DEPTH >= 2).
module dbf_reg_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           clr,
    input  logic                           push,
    input  logic [DW-1:0]                  push_data,
    input  logic                           pop,
    output logic [DW-1:0]                  head_data,
    output logic                           not_empty,
    output logic [$clog2(DEPTH+1)-1:0]     fill
);

    localparam int CW = $clog2(DEPTH + 1);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DW-1:0] slot [DEPTH];
    logic [PW-1:0] wp;
    logic [PW-1:0] rp;

    function automatic logic [PW-1:0] step_ptr(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    // Store the pushed word.
    always_ff @(posedge clk) begin : p_slot
        if (push) begin
            slot[wp] <= push_data;
        end
    end

    // Advance pointers and track occupancy.
    always_ff @(posedge clk) begin : p_ctrl
        if (!rst_n || clr) begin
            wp   <= '0;
            rp   <= '0;
            fill <= '0;
        end else begin
            if (push) wp <= step_ptr(wp);
            if (pop)  rp <= step_ptr(rp);
            case ({push, pop})
                2'b10:   fill <= fill + CW'(1);
                2'b01:   fill <= fill - CW'(1);
                default: fill <= fill;
            endcase
        end
    end

    assign head_data = slot[rp];
    assign not_empty = (fill != '0);

    AST_RF_NO_OVERFLOW:  assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (fill < CW'(DEPTH)));                                      // R7
    AST_RF_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (fill != '0));                                              // R2

endmodule

// File: rtl/dbf_bank.sv
// Half-rate FIFO bank: one single-port memory plus a register output queue.
// A write has the port when offered; otherwise a read is issued if the
// memory holds data and the output queue has room for everything already
// in flight. Assumes writes arrive at most every other cycle, which the
// steering in the top level guarantees, so reads fill the gaps.
module dbf_bank #(
    parameter int DW      = 8,
    parameter int AW      = 4,
    parameter int RF_DEPTH = 4,
    parameter int OCW     = AW + 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           wr_en,
    input  logic [DW-1:0]  wr_data,
    output logic           wr_ready,
    input  logic           pop,
    output logic           out_valid,
    output logic [DW-1:0]  out_data,
    output logic [OCW-1:0] occ
);

    localparam int SZ  = 1 << AW;
    localparam int MCW = AW + 1;
    localparam int RCW = $clog2(RF_DEPTH + 1);
    localparam int PCW = RCW + 2;

    logic [AW-1:0]  wptr;
    logic [AW-1:0]  rptr;
    logic [MCW-1:0] mcnt;
    logic [2:0]     rd_pipe;
    logic [RCW-1:0] rf_fill;
    logic [PCW-1:0] pend;
    logic           rd_issue;
    logic [AW-1:0]  ram_addr;
    logic [DW-1:0]  ram_rdata;

    // Items past the memory: in the read pipeline or in the output queue.
    assign pend = PCW'(rf_fill) + PCW'(rd_pipe[0]) + PCW'(rd_pipe[1]) + PCW'(rd_pipe[2]);

    assign wr_ready = (mcnt < MCW'(SZ));
    assign rd_issue = !wr_en && !clr && (mcnt != '0) && (pend < PCW'(RF_DEPTH));
    assign ram_addr = wr_en ? wptr : rptr;
    assign occ      = OCW'(mcnt) + OCW'(pend);

    dbf_sp_ram #(.DW(DW), .AW(AW)) u_ram (
        .clk   (clk),
        .addr  (ram_addr),
        .we    (wr_en),
        .wdata (wr_data),
        .rdata (ram_rdata)
    );

    // Memory pointers and stored-item count.
    always_ff @(posedge clk) begin : p_mem_ctrl
        if (!rst_n || clr) begin
            wptr <= '0;
            rptr <= '0;
            mcnt <= '0;
        end else begin
            if (wr_en)    wptr <= wptr + AW'(1);
            if (rd_issue) rptr <= rptr + AW'(1);
            case ({wr_en, rd_issue})
                2'b10:   mcnt <= mcnt + MCW'(1);
                2'b01:   mcnt <= mcnt - MCW'(1);
                default: mcnt <= mcnt;
            endcase
        end
    end

    // Valid tags that follow each read through the memory pipeline.
    always_ff @(posedge clk) begin : p_rd_pipe
        if (!rst_n || clr) begin
            rd_pipe <= '0;
        end else begin
            rd_pipe <= {rd_pipe[1:0], rd_issue};
        end
    end

    dbf_reg_fifo #(.DW(DW), .DEPTH(RF_DEPTH)) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .push      (rd_pipe[2]),
        .push_data (ram_rdata),
        .pop       (pop),
        .head_data (out_data),
        .not_empty (out_valid),
        .fill      (rf_fill)
    );

    AST_NO_OVERFLOW:  assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (mcnt < MCW'(SZ)));                                       // R7
    AST_HALF_RATE_IN: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);                                                  // R5

endmodule

// File: rtl/dual_bank_fifo.sv
// Full-rate synchronous FIFO from two half-rate single-port banks.
// Accepted items are dealt alternately to the banks by an input toggle;
// an output toggle pulls them back in the same order into a register
// queue that drives the port. Assumes AW >= 3 and
// 2*BANK_RF + OUT_RF < 2^(AW+1) so the count fits in AW+2 bits.
module dual_bank_fifo
    import dbf_pkg::*;
#(
    parameter int DW      = 8,
    parameter int AW      = 4,
    parameter int BANK_RF = 4,
    parameter int OUT_RF  = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            in_valid,
    input  logic [DW-1:0]   in_data,
    output logic            in_wait,
    output logic            out_valid,
    output logic [DW-1:0]   out_data,
    input  logic            out_wait,
    output logic [AW+1:0]   count
);

    localparam int CW       = AW + 2;
    localparam int OFW      = $clog2(OUT_RF + 1);
    localparam int CAPACITY = 2 * ((1 << AW) + BANK_RF) + OUT_RF;

    bank_sel_e in_sel;
    bank_sel_e out_sel;
    logic      isel;
    logic      osel;

    logic [NUM_BANKS-1:0] b_rdy;
    logic [NUM_BANKS-1:0] b_val;
    logic [DW-1:0]        b_dat [NUM_BANKS];
    logic [CW-1:0]        b_occ [NUM_BANKS];

    logic           in_acc;
    logic           out_acc;
    logic           pull;
    logic           o_ne;
    logic [OFW-1:0] o_fill;
    logic           o_room;

    assign isel    = (in_sel == SEL_B1);
    assign osel    = (out_sel == SEL_B1);
    assign in_wait = clr || !b_rdy[isel];
    assign in_acc  = in_valid && !in_wait;
    assign o_room  = (o_fill < OFW'(OUT_RF));
    assign pull    = b_val[osel] && o_room && !clr;
    assign out_valid = o_ne && !clr;
    assign out_acc = out_valid && !out_wait;
    assign count   = b_occ[0] + b_occ[1] + CW'(o_fill);

    // Input toggle: next accepted item goes to the other bank.
    always_ff @(posedge clk) begin : p_in_sel
        if (!rst_n || clr) begin
            in_sel <= SEL_B0;
        end else if (in_acc) begin
            in_sel <= (in_sel == SEL_B0) ? SEL_B1 : SEL_B0;
        end
    end

    // Output toggle: next item is pulled from the other bank.
    always_ff @(posedge clk) begin : p_out_sel
        if (!rst_n || clr) begin
            out_sel <= SEL_B0;
        end else if (pull) begin
            out_sel <= (out_sel == SEL_B0) ? SEL_B1 : SEL_B0;
        end
    end

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        localparam logic ME = 1'(g);
        dbf_bank #(.DW(DW), .AW(AW), .RF_DEPTH(BANK_RF), .OCW(CW)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (clr),
            .wr_en     (in_acc && (isel == ME)),
            .wr_data   (in_data),
            .wr_ready  (b_rdy[g]),
            .pop       (pull && (osel == ME)),
            .out_valid (b_val[g]),
            .out_data  (b_dat[g]),
            .occ       (b_occ[g])
        );
    end

    dbf_reg_fifo #(.DW(DW), .DEPTH(OUT_RF)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .push      (pull),
        .push_data (b_dat[osel]),
        .pop       (out_acc),
        .head_data (out_data),
        .not_empty (o_ne),
        .fill      (o_fill)
    );

    AST_COUNT_UP:    assert property (@(posedge clk) disable iff (!rst_n)
        (in_acc && !out_acc && !clr) |=> (count == $past(count) + CW'(1)));  // R6
    AST_COUNT_DOWN:  assert property (@(posedge clk) disable iff (!rst_n)
        (!in_acc && out_acc && !clr) |=> (count == $past(count) - CW'(1)));  // R6
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(CAPACITY));                                             // R7
    AST_OUT_HOLD:    assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_wait) |=> (clr || (out_valid && $stable(out_data)))); // R9
    AST_CLR_EMPTY:   assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0));                                              // R10

endmodule

// File: tb/sim_dual_bank_fifo.sv
module sim_dual_bank_fifo;

    localparam int CLK_P = 10;
    localparam int DW    = 8;
    localparam int AW    = 3;
    localparam int BRF   = 4;
    localparam int ORF   = 2;
    localparam int CW    = AW + 2;
    localparam int CAP   = 2 * ((1 << AW) + BRF) + ORF;
    localparam int LAT   = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clr = 1'b0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          out_wait = 1'b0;
    logic          in_wait;
    logic          out_valid;
    logic [DW-1:0] out_data;
    logic [CW-1:0] count;

    dual_bank_fifo #(.DW(DW), .AW(AW), .BANK_RF(BRF), .OUT_RF(ORF)) u0 (
        .clk, .rst_n, .clr, .in_valid, .in_data, .in_wait,
        .out_valid, .out_data, .out_wait, .count
    );

    always #(CLK_P / 2) clk = ~clk;

    int n_vec = 0;
    int n_bad = 0;
    int step_no = 0;
    logic [DW-1:0] mq_d [256];
    int mq_s [256];
    int mh = 0;
    int mt = 0;
    logic [DW-1:0] gen = 8'h11;
    bit lat_on = 0;
    bit stream_on = 0;
    bit prev_hold = 0;
    logic [DW-1:0] prev_data = '0;
    int n_acc = 0;
    logic [15:0] lf = 16'hACE1;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One cycle: drive inputs after a falling edge, check, update the model.
    task automatic step(input bit v, input bit ow, input bit c);
        in_valid = v;
        in_data  = gen;
        out_wait = ow;
        clr      = c;
        #1;
        chk(count == CW'(mt - mh), "R6", "count", int'(count), mt - mh);
        if (prev_hold && !c) begin
            chk(out_valid == 1'b1, "R9", "valid held", int'(out_valid), 1);
            chk(out_data == prev_data, "R9", "data held", int'(out_data), int'(prev_data));
        end
        if (c) begin
            chk(in_wait == 1'b1, "R10", "in_wait during clr", int'(in_wait), 1);
            chk(out_valid == 1'b0, "R10", "out_valid during clr", int'(out_valid), 0);
        end
        if (stream_on) chk(in_wait == 1'b0, "R5", "in_wait in stream", int'(in_wait), 0);
        if (out_valid && mt == mh) chk(0, "R2", "valid while empty", 1, 0);
        if (out_valid && !ow && mt != mh) begin
            chk(out_data == mq_d[mh % 256], "R3", "out_data", int'(out_data), int'(mq_d[mh % 256]));
            if (lat_on) chk(step_no - mq_s[mh % 256] == LAT, "R4", "latency",
                            step_no - mq_s[mh % 256], LAT);
            mh++;
        end
        if (v && !in_wait) begin
            mq_d[mt % 256] = gen;
            mq_s[mt % 256] = step_no;
            mt++;
            n_acc++;
            gen = gen + 8'd7;
        end
        if (c) mh = mt;
        prev_hold = out_valid && ow && !c;
        prev_data = out_data;
        @(negedge clk);
        step_no++;
    endtask

    initial begin : watchdog
        #(CLK_P * 200000);
        n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : main
        int base;
        repeat (3) @(negedge clk);
        #1;
        chk(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
        chk(count == '0, "R1", "count in reset", int'(count), 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
        chk(count == '0, "R1", "count after reset", int'(count), 0);
        chk(in_wait == 1'b0, "R1", "in_wait after reset", int'(in_wait), 0);
        @(negedge clk);

        // R4: single item through an empty buffer.
        lat_on = 1;
        step(1, 0, 0);
        for (int i = 0; i < 10; i++) step(0, 0, 0);
        chk(mh == mt, "R4", "single item delivered", mh, mt);

        // R5: unbroken stream, no backpressure.
        stream_on = 1;
        for (int i = 0; i < 40; i++) step(1, 0, 0);
        stream_on = 0;
        for (int i = 0; i < 12; i++) step(0, 0, 0);
        chk(mh == mt, "R5", "stream delivered", mh, mt);
        lat_on = 0;

        // R7/R8: fill with output held, then keep offering.
        base = n_acc;
        for (int i = 0; i < 60; i++) step(1, 1, 0);
        chk(n_acc - base == CAP, "R7", "capacity", n_acc - base, CAP);
        #1;
        chk(in_wait == 1'b1, "R7", "in_wait when full", int'(in_wait), 1);
        for (int i = 0; i < 5; i++) step(1, 1, 0);
        chk(n_acc - base == CAP, "R8", "refused items", n_acc - base, CAP);
        chk(count == CW'(CAP), "R8", "count after refused", int'(count), CAP);
        for (int i = 0; i < 50; i++) step(0, 0, 0);
        chk(mh == mt, "R3", "drain complete", mh, mt);

        // R10: flush with the input toggle on bank 1, then restart.
        for (int i = 0; i < 3; i++) step(1, 1, 0);
        for (int i = 0; i < 8; i++) step(0, 1, 0);
        step(1, 1, 1);
        step(0, 0, 0);
        chk(count == '0, "R10", "count after clr", int'(count), 0);
        lat_on = 1;
        step(1, 0, 0);
        step(1, 0, 0);
        step(1, 0, 0);
        for (int i = 0; i < 10; i++) step(0, 0, 0);
        chk(mh == mt, "R10", "items after clr delivered", mh, mt);
        lat_on = 0;

        // Random offers, backpressure and rare flushes against the model.
        for (int i = 0; i < 4000; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step(lf[2] | lf[5], lf[7] & ~lf[9], (lf[15:9] == 7'h5A));
        end
        for (int i = 0; i < 60; i++) step(0, 0, 0);
        chk(mh == mt, "R3", "random drain complete", mh, mt);
        chk(count == '0, "R6", "final count", int'(count), 0);

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule